// File: doc/BRIEF.md
# Signed Adder-Subtractor with Status Flags

This block is a purely combinational arithmetic unit for two's complement integers. It takes two signed operands and a one-bit operation select. It returns the sum or the difference, truncated to the operand width, together with three status flags. The flags report a zero result, a negative result and signed overflow.

Subtraction does not use a second adder. When the select is high, every bit of the second operand is inverted by an XOR gate, and the adder's carry-in is set to one, so the block computes A + ~B + 1. The carry network inside the adder can be a ripple chain or a flattened lookahead network, chosen by a parameter. Both give the same outputs.

Overflow is taken from the carry entering the top bit and the carry leaving it, so the adder brings out both carries. The zero flag looks only at the result bits and never at the final carry.

Top module: `addsub_flags`

## Requirements
- R1: With `sub` = 0, `result` equals (`opa` + `opb`) modulo 2^W, where W = 8 by default.
- R2: With `sub` = 1, `result` equals (`opa` - `opb`) modulo 2^W. It is formed as `opa` + ~`opb` + 1.
- R3: `zero` is 1 exactly when all bits of `result` are 0. The carry out of the top bit plays no part: 5 - 5 gives `zero` = 1 even though the carry out is 1.
- R4: `sign` equals bit W-1 of `result`.
- R5: `ovf` is 1 exactly when the true signed result of the selected operation lies outside -2^(W-1) .. 2^(W-1)-1. This is the XOR of the carry into bit W-1 and the carry out of bit W-1.
- R6: No overflow ever occurs in two cases: an addition of operands with opposite signs, and a subtraction of operands with the same sign.
- R7: The extreme cases give these outputs:
  - -128 - 1 gives `result` = 127 with `ovf` = 1.
  - 0 - (-128) gives `result` = -128 (0x80) with `ovf` = 1.
  - -128 + -128 gives `result` = 0 with `zero` = 1 and `ovf` = 1.
- R8: Parameter `LOOKAHEAD` selects the carry network: 0 for the ripple chain, 1 for the lookahead network. Both give identical `result`, `zero`, `sign` and `ovf` for every input.
- R9: The block holds no state. The outputs follow the inputs with no clock, and they depend only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W | First signed operand |
| opb | input | W | Second signed operand |
| sub | input | 1 | 0 = add, 1 = subtract |
| result | output | W | Signed result, truncated to W bits |
| zero | output | 1 | Result bits are all zero |
| sign | output | 1 | Top bit of the result |
| ovf | output | 1 | Signed overflow |

## Verification
The bench sweeps every operand pair in both operations, so these cases are all covered:
- all four sign combinations;
- the most negative operand;
- zero results that leave a carry out.

Each corner case catches a particular fault:
- A zero flag that includes the final carry would report 5 - 5 as nonzero.
- Overflow taken from the carry out alone, or from the wrong carry pair, would miss 0 - (-128) or would flag harmless mixed-sign additions.
- A missing carry-in during subtraction would leave every difference one too small.

Both carry networks are instantiated side by side and compared on every vector. A lookahead term that is wrong for a single bit position therefore shows up as a mismatch.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int W         = 8,
  parameter int LOOKAHEAD = 0
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         sign,
  output logic         ovf
);

  logic [W-1:0] bx;
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:1]   cy;
  logic [W:0]   c;

  assign bx   = opb ^ {W{sub}};
  assign gen  = opa & bx;
  assign prop = opa ^ bx;
  assign c    = {cy, sub};

  generate
    if (LOOKAHEAD == 0) begin : g_ripple
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign cy[i+1] = gen[i] | (prop[i] & c[i]);
      end
    end else begin : g_cla
      always_comb begin
        for (int i = 0; i < W; i++) begin
          logic acc;
          logic term;
          term = sub;
          for (int k = 0; k <= i; k++) term = term & prop[k];
          acc = term;
          for (int j = 0; j <= i; j++) begin
            term = gen[j];
            for (int k = j + 1; k <= i; k++) term = term & prop[k];
            acc = acc | term;
          end
          cy[i+1] = acc;
        end
      end
    end
  endgenerate

  assign result = prop ^ c[W-1:0];
  assign zero   = ~|result;
  assign sign   = result[W-1];
  assign ovf    = c[W] ^ c[W-1];

  logic [W:0] ext_a;
  logic [W:0] ext_b;
  logic [W:0] exact;

  assign ext_a = {opa[W-1], opa};
  assign ext_b = {opb[W-1], opb};
  assign exact = sub ? (ext_a - ext_b) : (ext_a + ext_b);

  always_comb begin
    if (!$isunknown({opa, opb, sub})) begin
      a_r1_r2_value: assert (result == exact[W-1:0])
        else $error("adder result disagrees with arithmetic");
      a_r5_overflow: assert (ovf == (exact[W] != exact[W-1]))
        else $error("carry-based overflow disagrees with range check");
      a_r6_no_overflow: assert (!((opa[W-1] != bx[W-1]) && ovf))
        else $error("overflow with differing effective signs");
      a_r3_zero_sub: assert (!(sub && zero) || (opa == opb))
        else $error("zero in subtraction without equal operands");
      a_r4_true_sign: assert ((sign ^ ovf) == exact[W])
        else $error("sign with overflow correction wrong");
    end
  end

endmodule

// File: tb/addsub_flags_test.sv
module addsub_flags_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] opa, opb;
  logic         sub;
  logic [W-1:0] res_r, res_c;
  logic         z_r, s_r, v_r, z_c, s_c, v_c;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  addsub_flags #(.W(W), .LOOKAHEAD(0)) uut (
    .opa(opa), .opb(opb), .sub(sub),
    .result(res_r), .zero(z_r), .sign(s_r), .ovf(v_r));

  addsub_flags #(.W(W), .LOOKAHEAD(1)) uut_cla (
    .opa(opa), .opb(opb), .sub(sub),
    .result(res_c), .zero(z_c), .sign(s_c), .ovf(v_c));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d sub=%0b)",
               tag, act, exp, $signed(opa), $signed(opb), sub);
    end
  endtask

  task automatic apply(input int a, input int b, input bit s);
    @(posedge clk);
    opa = a[W-1:0];
    opb = b[W-1:0];
    sub = s;
    #2;
  endtask

  task automatic full_check();
    int sa, sb, ex;
    logic [W-1:0] er;
    bit ev;
    sa = $signed(opa);
    sb = $signed(opb);
    ex = sub ? sa - sb : sa + sb;
    er = ex[W-1:0];
    ev = (ex > 127) || (ex < -128);
    check(res_r == er, sub ? "R2 result" : "R1 result", int'(res_r), int'(er));
    check(z_r == (er == 0), "R3 zero", int'(z_r), int'(er == 0));
    check(s_r == er[W-1], "R4 sign", int'(s_r), int'(er[W-1]));
    check(v_r == ev, "R5 ovf", int'(v_r), int'(ev));
    if ((!sub && (sa < 0) != (sb < 0)) || (sub && (sa < 0) == (sb < 0)))
      check(v_r == 1'b0, "R6 never overflow", int'(v_r), 0);
    check({res_c, z_c, s_c, v_c} == {res_r, z_r, s_r, v_r}, "R8 arch match",
          int'({res_c, z_c, s_c, v_c}), int'({res_r, z_r, s_r, v_r}));
  endtask

  initial begin
    opa = '0; opb = '0; sub = 1'b0;
    #2;
    check(res_r == 0 && z_r && !s_r && !v_r, "R3 initial zero inputs",
          int'({res_r, z_r, s_r, v_r}), 32'h004);

    // R9: outputs follow inputs without any clock edge
    @(negedge clk);
    opa = 8'd3; opb = 8'd4; sub = 1'b0;
    #1;
    check(res_r == 8'd7, "R9 no clock needed", int'(res_r), 7);

    apply(5, 5, 1);
    check(res_r == 0 && z_r == 1, "R3 5-5 zero with carry out", int'(z_r), 1);
    check(z_c == 1, "R8 R3 lookahead 5-5", int'(z_c), 1);

    apply(-128, 1, 1);
    check(res_r == 8'd127 && v_r, "R7 -128-1", int'({v_r, res_r}), 32'h17f);
    apply(0, -128, 1);
    check(res_r == 8'h80 && v_r && s_r, "R7 0-(-128)", int'({v_r, res_r}), 32'h180);
    apply(-128, -128, 0);
    check(res_r == 0 && z_r && v_r, "R7 -128+-128", int'({z_r, v_r}), 3);
    apply(-112, -12, 1);
    check($signed(res_r) == -100 && !v_r, "R2 -112-(-12)", $signed(res_r), -100);
    apply(100, 50, 0);
    check(v_r && s_r, "R5 positive overflow", int'({v_r, s_r}), 3);

    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++) begin
          apply(a, b, s[0]);
          full_check();
        end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cycles = 0;
    while (cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule